// File: doc/BRIEF.md
# Interrupt Unit Mode and Base Register Controller

This block holds the mode-and-base register of one local interrupt unit and guards every change to it. The register carries a page-aligned base address, a global enable, an extended-addressing enable and a bootstrap-processor flag. A write request arrives on a single-cycle valid strobe with a 32-bit value. The controller checks the requested mode against the current mode and against a capability input, then either commits the write or rejects it.

Each request gets exactly one one-cycle response pulse, either accepted or rejected, one clock after the strobe. When a write turns the unit off, the controller also pulses a request to clear the software-enable bit held in the unit's spurious-vector register. When a write enters or re-enters extended mode, the controller derives a clustered logical ID from the unit's initial ID: the cluster number in the upper half and a one-hot member bit in the lower half.

The reset input is asynchronous and active low, and its release is synchronised inside the block. After reset the unit is enabled in legacy mode, the bootstrap flag is taken from a strap input, and the base holds a parameter value.

Top module: `lmc_mode_ctrl`

## Requirements
- R1: After reset the unit is enabled, extended mode is off, the bootstrap flag equals `bsp_strap`, the base equals `RESET_BASE`, the logical ID is zero, and the response pulses and the clear pulse are low.
- R2: A write with the extended bit (bit 10) set is rejected while `ext_cap` is low.
- R3: A write with the enable bit (bit 11) clear and the extended bit set is rejected.
- R4: When the unit is disabled, a write with both the enable and extended bits set is rejected.
- R5: When the unit is enabled in extended mode, a write with enable set and extended clear is rejected.
- R6: A rejected write leaves enable, extended mode, base, bootstrap flag and logical ID unchanged. It raises `wr_err` for exactly one cycle, the cycle after the strobe, and `wr_ok` stays low.
- R7: An accepted write loads the base from value bits [31:12] and raises `wr_ok` for one cycle. The bootstrap flag keeps its previous value whatever value bit 8 holds.
- R8: An accepted write with the enable bit clear disables the unit, clears extended mode and raises `sw_enable_clr` for one cycle.
- R9: An accepted write with enable set and extended clear, made while the unit is disabled, enables the unit in legacy mode.
- R10: An accepted write with the extended bit set, made while the unit is enabled in legacy mode, enters extended mode. The logical ID becomes {init_id[19:4], 16'b0} OR (1 << init_id[3:0]).
- R11: A write with enable and extended set, made while the unit is already in extended mode, is accepted and recomputes the logical ID from the present `init_id`.
- R12: With `wr_valid` low, no state or output changes, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsp_strap | input | 1 | Bootstrap-processor strap, loaded at reset |
| ext_cap | input | 1 | High when extended mode is supported |
| init_id | input | ID_W | Initial unit ID |
| wr_valid | input | 1 | Write strobe, one cycle |
| wr_data | input | REG_W | Requested register value |
| wr_ok | output | 1 | Write accepted, one-cycle pulse |
| wr_err | output | 1 | Write rejected, one-cycle pulse |
| unit_enabled | output | 1 | Global enable state |
| ext_mode | output | 1 | Extended mode state |
| bsp_flag | output | 1 | Bootstrap-processor flag |
| base_addr | output | BASE_W | Page-aligned base address (bits [31:12]) |
| sw_enable_clr | output | 1 | Pulse requesting a software-enable clear |
| ext_logical_id | output | LID_W | Derived clustered logical ID |

## Verification
The bench builds the block with its default widths: a 32-bit register, a 16-bit cluster field and a 4-bit member field. It overrides `RESET_BASE` with a value other than the default, so the reset check shows that the base comes from the parameter. The initial IDs are chosen so that member indices 7 and 15 are both reached. This exercises the top end of the one-hot decode and a cluster number that fills the whole upper half of the ID. Every forbidden mode change is reached from the mode it is forbidden in, and every accepted path among disabled, legacy and extended modes is also taken.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned PAGE_LSB = 12;
  localparam int unsigned EN_POS   = 11;
  localparam int unsigned EXT_POS  = 10;
  localparam int unsigned BSP_POS  = 8;

  typedef struct packed {
    logic en;
    logic ext;
    logic bsp;
  } mode_t;
endpackage

// File: rtl/lmc_rst_sync.sv
module lmc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lmc_xition_check.sv
module lmc_xition_check (
  input  logic cur_en,
  input  logic cur_ext,
  input  logic cap,
  input  logic req_en,
  input  logic req_ext,
  output logic legal
);
  logic no_cap, bad_state, off_to_ext, ext_to_legacy;

  always_comb begin
    no_cap        = req_ext && !cap;
    bad_state     = req_ext && !req_en;
    off_to_ext    = !cur_en && req_en && req_ext;
    ext_to_legacy = cur_en && cur_ext && req_en && !req_ext;
    legal         = !(no_cap || bad_state || off_to_ext || ext_to_legacy);
  end
endmodule

// File: rtl/lmc_xid_gen.sv
module lmc_xid_gen #(
  parameter int unsigned ID_W      = 32,
  parameter int unsigned CLUSTER_W = 16,
  parameter int unsigned MEMBER_W  = 4,
  localparam int unsigned MEMBERS  = 1 << MEMBER_W,
  localparam int unsigned LID_W    = CLUSTER_W + MEMBERS
) (
  input  logic [ID_W-1:0]  init_id,
  output logic [LID_W-1:0] lid
);
  logic [MEMBER_W-1:0] member;
  assign member = init_id[MEMBER_W-1:0];

  assign lid[LID_W-1:MEMBERS] = init_id[MEMBER_W+CLUSTER_W-1:MEMBER_W];

  for (genvar g = 0; g < MEMBERS; g++) begin : g_member
    assign lid[g] = (member == MEMBER_W'(g));
  end
endmodule

// File: rtl/lmc_mode_ctrl.sv
module lmc_mode_ctrl
  import lmc_pkg::*;
#(
  parameter int unsigned ID_W      = 32,
  parameter int unsigned CLUSTER_W = 16,
  parameter int unsigned MEMBER_W  = 4,
  localparam int unsigned BASE_W   = REG_W - PAGE_LSB,
  localparam int unsigned LID_W    = CLUSTER_W + (1 << MEMBER_W),
  parameter logic [BASE_W-1:0] RESET_BASE = 20'hFEE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsp_strap,
  input  logic              ext_cap,
  input  logic [ID_W-1:0]   init_id,
  input  logic              wr_valid,
  input  logic [REG_W-1:0]  wr_data,
  output logic              wr_ok,
  output logic              wr_err,
  output logic              unit_enabled,
  output logic              ext_mode,
  output logic              bsp_flag,
  output logic [BASE_W-1:0] base_addr,
  output logic              sw_enable_clr,
  output logic [LID_W-1:0]  ext_logical_id
);
  logic rst_sync_n;
  logic req_en, req_ext, legal;
  logic [LID_W-1:0] lid_new;

  mode_t             mode_q, mode_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [LID_W-1:0]  lid_q, lid_d;
  logic              ok_d, err_d, clr_d;
  logic              ok_q, err_q, clr_q;
  logic              state_ce, lid_ce;

  lmc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign req_en  = wr_data[EN_POS];
  assign req_ext = wr_data[EXT_POS];

  lmc_xition_check u_chk (
    .cur_en(mode_q.en), .cur_ext(mode_q.ext), .cap(ext_cap),
    .req_en(req_en), .req_ext(req_ext), .legal(legal)
  );

  lmc_xid_gen #(.ID_W(ID_W), .CLUSTER_W(CLUSTER_W), .MEMBER_W(MEMBER_W)) u_xid (
    .init_id(init_id), .lid(lid_new)
  );

  // next-state
  always_comb begin
    state_ce = wr_valid && legal;
    lid_ce   = state_ce && req_ext;
    ok_d     = state_ce;
    err_d    = wr_valid && !legal;
    clr_d    = state_ce && !req_en;
    base_d   = wr_data[REG_W-1:PAGE_LSB];
    mode_d.bsp = mode_q.bsp;
    mode_d.en  = req_en;
    mode_d.ext = req_en && req_ext;
    lid_d    = lid_new;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q.en  <= 1'b1;
      mode_q.ext <= 1'b0;
      mode_q.bsp <= bsp_strap;
      base_q     <= RESET_BASE;
    end else if (state_ce) begin
      mode_q <= mode_d;
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  lid_q <= '0;
    else if (lid_ce)  lid_q <= lid_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      err_q <= err_d;
      clr_q <= clr_d;
    end
  end

  assign wr_ok          = ok_q;
  assign wr_err         = err_q;
  assign sw_enable_clr  = clr_q;
  assign unit_enabled   = mode_q.en;
  assign ext_mode       = mode_q.ext;
  assign bsp_flag       = mode_q.bsp;
  assign base_addr      = base_q;
  assign ext_logical_id = lid_q;
endmodule

// File: rtl/lmc_mode_ctrl_chk.sv
module lmc_mode_ctrl_chk #(
  parameter int unsigned BASE_W = 20,
  parameter int unsigned LID_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_cap,
  input logic              wr_valid,
  input logic              wr_ok,
  input logic              wr_err,
  input logic              unit_enabled,
  input logic              ext_mode,
  input logic              bsp_flag,
  input logic [BASE_W-1:0] base_addr,
  input logic              sw_enable_clr,
  input logic [LID_W-1:0]  ext_logical_id
);
  AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($stable(unit_enabled) && $stable(ext_mode) && $stable(base_addr)
                && $stable(bsp_flag) && $stable(ext_logical_id))); // R6
  AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && wr_err)); // R6
  AST_EXT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> unit_enabled); // R3
  AST_EXT_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_mode) |-> $past(ext_cap)); // R2
  AST_NO_OFF_TO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unit_enabled) |-> !ext_mode); // R4
  AST_NO_EXT_TO_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_mode) |-> !unit_enabled); // R5
  AST_CLR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sw_enable_clr |-> (!unit_enabled && wr_ok)); // R8
  AST_BSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bsp_flag)); // R7
  AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> (!wr_ok && !wr_err)); // R12
endmodule

bind lmc_mode_ctrl lmc_mode_ctrl_chk #(.BASE_W(BASE_W), .LID_W(LID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ext_cap(ext_cap), .wr_valid(wr_valid),
  .wr_ok(wr_ok), .wr_err(wr_err), .unit_enabled(unit_enabled),
  .ext_mode(ext_mode), .bsp_flag(bsp_flag), .base_addr(base_addr),
  .sw_enable_clr(sw_enable_clr), .ext_logical_id(ext_logical_id)
);

// File: tb/lmc_mode_ctrl_tb_top.sv
module lmc_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] TB_RESET_BASE = 20'hABCDE;

  typedef struct {
    string       req;
    logic        ok, err, en, ext, bsp, clr;
    logic [19:0] base;
    logic [31:0] lid;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n, bsp_strap, ext_cap, wr_valid;
  logic [31:0] init_id, wr_data;
  logic        wr_ok, wr_err, unit_enabled, ext_mode, bsp_flag, sw_enable_clr;
  logic [19:0] base_addr;
  logic [31:0] ext_logical_id;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic due = 1'b0;
  logic armed = 1'b0;
  logic done = 1'b0;

  // bench model state
  logic        m_en, m_ext, m_bsp;
  logic [19:0] m_base;
  logic [31:0] m_lid;

  always #(CLK_PERIOD/2) clk = ~clk;

  lmc_mode_ctrl #(.RESET_BASE(TB_RESET_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bsp_strap(bsp_strap), .ext_cap(ext_cap),
    .init_id(init_id), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ok(wr_ok), .wr_err(wr_err), .unit_enabled(unit_enabled),
    .ext_mode(ext_mode), .bsp_flag(bsp_flag), .base_addr(base_addr),
    .sw_enable_clr(sw_enable_clr), .ext_logical_id(ext_logical_id)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cmp_state(input exp_t e);
    chk(e.req, "wr_ok",  32'(wr_ok),  32'(e.ok));
    chk(e.req, "wr_err", 32'(wr_err), 32'(e.err));
    chk(e.req, "enable", 32'(unit_enabled), 32'(e.en));
    chk(e.req, "ext",    32'(ext_mode), 32'(e.ext));
    chk(e.req, "bsp",    32'(bsp_flag), 32'(e.bsp));
    chk(e.req, "clr",    32'(sw_enable_clr), 32'(e.clr));
    chk(e.req, "base",   32'(base_addr), 32'(e.base));
    chk(e.req, "lid",    ext_logical_id, e.lid);
  endtask

  function automatic exp_t snap(input string req);
    exp_t e;
    e.req = req; e.ok = 1'b0; e.err = 1'b0; e.clr = 1'b0;
    e.en = m_en; e.ext = m_ext; e.bsp = m_bsp; e.base = m_base; e.lid = m_lid;
    return e;
  endfunction

  // driver: computes expected result, pushes it, applies one write
  task automatic do_write(input string req, input logic [31:0] v,
                          input logic cap, input logic [31:0] id);
    logic ve, vx, bad;
    exp_t e;
    ve = v[11]; vx = v[10];
    bad = (vx && !cap) || (vx && !ve) || (!m_en && ve && vx)
          || (m_en && m_ext && ve && !vx);
    if (!bad) begin
      m_base = v[31:12];
      m_en   = ve;
      m_ext  = ve && vx;
      if (vx) m_lid = {id[19:4], 16'h0} | (32'd1 << id[3:0]);
    end
    e = snap(req);
    e.ok = !bad; e.err = bad; e.clr = !bad && !ve;
    q.push_back(e);
    @(negedge clk);
    ext_cap = cap; init_id = id; wr_data = v; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_data = 32'hDEAD_BEEF;
  endtask

  // monitor
  always @(posedge clk) due <= wr_valid;

  always @(negedge clk) begin
    if (due) begin
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected response actual=queue_empty expected=item");
      end else cmp_state(q.pop_front());
    end else if (armed) begin
      chk("R6", "idle wr_ok", 32'(wr_ok), 32'd0);
      chk("R6", "idle wr_err", 32'(wr_err), 32'd0);
      chk("R8", "idle clr", 32'(sw_enable_clr), 32'd0);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bsp_strap = 1'b1; ext_cap = 1'b0; init_id = '0;
    wr_valid = 1'b0; wr_data = '0;
    m_en = 1'b1; m_ext = 1'b0; m_bsp = 1'b1; m_base = TB_RESET_BASE; m_lid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_state(snap("R1"));
    armed = 1'b1;

    do_write("R7",  32'h1234_5800, 1'b0, 32'h0);          // accept, bsp bit 0 ignored
    do_write("R2",  32'h0000_0C00, 1'b0, 32'h0);          // ext without capability
    do_write("R3",  32'h0000_0400, 1'b1, 32'h0);          // ext with enable clear
    do_write("R10", 32'h5555_5C00, 1'b1, 32'h000A_B3C7);  // legacy -> ext
    do_write("R5",  32'h5555_5800, 1'b1, 32'h000A_B3C7);  // ext -> legacy
    do_write("R11", 32'h6666_6D00, 1'b1, 32'h0005_000F);  // stay ext, new ID
    do_write("R8",  32'h7777_7000, 1'b1, 32'h0);          // ext -> off
    do_write("R4",  32'h8888_8C00, 1'b1, 32'h0);          // off -> ext
    do_write("R8",  32'h9999_9100, 1'b0, 32'h0);          // off -> off
    do_write("R9",  32'hAAAA_A800, 1'b0, 32'h0);          // off -> legacy

    // R12: garbage on the data bus without a strobe
    @(negedge clk);
    wr_data = 32'hFFFF_FFFF; ext_cap = 1'b1; init_id = 32'h000F_FFFF;
    repeat (3) @(negedge clk);
    cmp_state(snap("R12"));
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule